// File: doc/BRIEF.md
# Packed Integer Vector ALU

This block is a 64-bit packed integer arithmetic and logic unit for a media or signal-processing datapath. Each operation takes two 64-bit operands, an operation code and a lane-size code. The word is split into independent lanes of 8, 16 or 32 bits, and every lane is computed on its own with no carry crossing a lane boundary. Add and subtract come in three forms: wrap-around, signed-saturating and unsigned-saturating. Compares write an all-ones or all-zeros mask into each lane. The bitwise operations act on the whole 64-bit word.

The unit raises no carry, overflow or condition flags. Branch-free code gets its data-dependent behaviour by combining compare masks with the bitwise operations. The result is registered, and a valid strobe travels with it.

Top module: `simd_alu`

## Requirements
- R1: `in_size` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 gives two 32-bit lanes. Op 0 (wrap add) adds each lane modulo its width, and no carry reaches the neighbouring lane.
- R2: Op 3 (wrap subtract) computes `in_a - in_b` in each lane modulo the lane width, and no borrow crosses a lane boundary.
- R3: Op 1 (signed saturating add) and op 4 (signed saturating subtract) treat lanes as two's complement. A result above the lane maximum becomes 0x7F.., and a result below the lane minimum becomes 0x80...
- R4: Op 2 (unsigned saturating add) clamps overflow to all ones. Op 5 (unsigned saturating subtract) clamps any negative result to zero.
- R5: With 32-bit lanes, the saturating ops 1, 2, 4 and 5 behave as their wrap-around counterparts.
- R6: Op 6 (equal) writes all ones to a lane whose operands match and all zeros otherwise.
- R7: Op 7 (greater-than) writes all ones to a lane where `in_a` is greater than `in_b` as signed numbers, and all zeros otherwise. No less-than op exists.
- R8: Op 8 gives `in_a & in_b`, op 10 gives `in_a | in_b` and op 11 gives `in_a ^ in_b`, all over the full 64 bits.
- R9: Op 9 (and-not) gives `~in_a & in_b` over the full 64 bits.
- R10: ORing the op 5 result for (a, b) with the op 5 result for (b, a) gives the unsigned absolute difference of every byte lane.
- R11: A valid input is captured on the next rising edge. `out_valid` is `in_valid` delayed by one cycle. `out_result` holds its value while `in_valid` is low. Synchronous active-high `rst` clears `out_valid` and `out_result`.
- R12: Op codes 12 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Lane-width code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | `out_result` holds a new result |
| out_result | output | 64 | Registered packed result |

## Verification
Every result is due exactly one rising edge after the cycle in which it is presented with `in_valid` high. The bench drives inputs on the falling edge and reads `out_result` and `out_valid` on the following falling edge, so each check lands in the first cycle after the capturing edge. For the hold and reset cases, `in_valid` or `rst` changes on a falling edge, and the bench samples one full cycle later.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int WORD_W = 64;
  localparam int BASE_LANE_W = 8;
  localparam int NUM_SIZES = 3;
  localparam int SAT_LIMIT_W = 16;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDS  = 4'd1,
    OP_ADDUS = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBS  = 4'd4,
    OP_SUBUS = 4'd5,
    OP_CEQ   = 4'd6,
    OP_CGT   = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SAT_NONE     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2
  } sat_mode_e;
endpackage

// File: rtl/simd_addsub_lanes.sv
module simd_addsub_lanes
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SAT_MAX_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  sat_mode_e         mode,
  output logic [DATA_W-1:0] res
);
  localparam int  LANES = DATA_W / LANE_W;
  localparam bit  SAT_EN = (LANE_W <= SAT_MAX_W);

  // One lane: wide sum in both interpretations, then clamp per mode.
  function automatic logic [LANE_W-1:0] lane_op(
    input logic [LANE_W-1:0] x,
    input logic [LANE_W-1:0] y,
    input logic              do_sub,
    input sat_mode_e         m
  );
    logic [LANE_W:0] uw, sw;
    logic [LANE_W-1:0] smax, smin;
    smax = {1'b0, {(LANE_W-1){1'b1}}};
    smin = {1'b1, {(LANE_W-1){1'b0}}};
    uw = do_sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
    sw = do_sub ? ({x[LANE_W-1], x} - {y[LANE_W-1], y})
                : ({x[LANE_W-1], x} + {y[LANE_W-1], y});
    case (m)
      SAT_UNSIGNED: begin
        if (uw[LANE_W]) lane_op = do_sub ? '0 : '1;
        else            lane_op = uw[LANE_W-1:0];
      end
      SAT_SIGNED: begin
        if (sw[LANE_W] != sw[LANE_W-1]) lane_op = sw[LANE_W] ? smin : smax;
        else                            lane_op = sw[LANE_W-1:0];
      end
      default: lane_op = uw[LANE_W-1:0];
    endcase
  endfunction

  sat_mode_e eff_mode;
  generate
    if (SAT_EN) begin : g_sat
      assign eff_mode = mode;
    end else begin : g_nosat
      assign eff_mode = SAT_NONE;
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign res[i*LANE_W +: LANE_W] =
      lane_op(a[i*LANE_W +: LANE_W], b[i*LANE_W +: LANE_W], sub, eff_mode);
  end
endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] eq_mask,
  output logic [DATA_W-1:0] gt_mask
);
  localparam int LANES = DATA_W / LANE_W;

  function automatic logic signed_gt(input logic [LANE_W-1:0] x,
                                     input logic [LANE_W-1:0] y);
    return $signed(x) > $signed(y);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a[i*LANE_W +: LANE_W];
    assign lb = b[i*LANE_W +: LANE_W];
    assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{la == lb}};
    assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{signed_gt(la, lb)}};
  end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        fn,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (fn)
      2'd0:    res = a & b;
      2'd1:    res = ~a & b;
      2'd2:    res = a | b;
      default: res = a ^ b;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [3:0]  in_op,
  input  logic [1:0]  in_size,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_valid,
  output logic [63:0] out_result
);
  localparam int SZ_IDX_W = $clog2(NUM_SIZES);

  alu_op_e   op_e;
  logic      is_sub;
  sat_mode_e mode;
  logic [SZ_IDX_W-1:0] sz_idx;

  assign op_e   = alu_op_e'(in_op);
  assign is_sub = (op_e == OP_SUB) || (op_e == OP_SUBS) || (op_e == OP_SUBUS);
  assign sz_idx = (in_size >= 2'(NUM_SIZES)) ? SZ_IDX_W'(NUM_SIZES - 1)
                                             : SZ_IDX_W'(in_size);

  always_comb begin
    case (op_e)
      OP_ADDS, OP_SUBS:   mode = SAT_SIGNED;
      OP_ADDUS, OP_SUBUS: mode = SAT_UNSIGNED;
      default:            mode = SAT_NONE;
    endcase
  end

  logic [WORD_W-1:0] arith_all [NUM_SIZES];
  logic [WORD_W-1:0] eq_all    [NUM_SIZES];
  logic [WORD_W-1:0] gt_all    [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    simd_addsub_lanes #(
      .DATA_W(WORD_W), .LANE_W(BASE_LANE_W << s), .SAT_MAX_W(SAT_LIMIT_W)
    ) u_addsub (
      .a(in_a), .b(in_b), .sub(is_sub), .mode(mode), .res(arith_all[s])
    );
    simd_cmp_lanes #(
      .DATA_W(WORD_W), .LANE_W(BASE_LANE_W << s)
    ) u_cmp (
      .a(in_a), .b(in_b), .eq_mask(eq_all[s]), .gt_mask(gt_all[s])
    );
  end

  // Named wires for the selected lane width, used by the assertions.
  logic [WORD_W-1:0] arith_sel, eq_sel, gt_sel, logic_res, next_res;
  assign arith_sel = arith_all[sz_idx];
  assign eq_sel    = eq_all[sz_idx];
  assign gt_sel    = gt_all[sz_idx];

  simd_logic_unit #(.DATA_W(WORD_W)) u_logic (
    .a(in_a), .b(in_b), .fn(in_op[1:0]), .res(logic_res)
  );

  always_comb begin
    case (op_e)
      OP_ADD, OP_ADDS, OP_ADDUS,
      OP_SUB, OP_SUBS, OP_SUBUS:        next_res = arith_sel;
      OP_CEQ:                           next_res = eq_sel;
      OP_CGT:                           next_res = gt_sel;
      OP_AND, OP_ANDN, OP_OR, OP_XOR:   next_res = logic_res;
      default:                          next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_res;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result))); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0)); // R11
  AST_CMP_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (eq_sel & gt_sel) == '0); // R7
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_CEQ && in_a == in_b) |=> out_result == '1); // R6
  AST_ANDN_CLEARS_A: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ANDN) |=> (out_result & $past(in_a)) == '0); // R9
  AST_USUB_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_SUBUS && in_a == in_b) |-> arith_sel == '0); // R4
endmodule

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  simd_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  // {op, size, a, b, expected}
  localparam int NV = 20;
  localparam logic [197:0] VEC [NV] = '{
    {4'd0, 2'd0, 64'h0102_0304_FF80_7F10, 64'h0101_0101_0180_0110, 64'h0203_0405_0000_8020}, // R1
    {4'd0, 2'd1, 64'hFFFF_0001_7FFF_1234, 64'h0001_0001_0001_1111, 64'h0000_0002_8000_2345}, // R1
    {4'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 64'h0000_0000_0000_0003}, // R1
    {4'd3, 2'd0, 64'h0010_80FF_0000_0005, 64'h0101_0101_0000_0006, 64'hFF0F_7FFE_0000_00FF}, // R2
    {4'd1, 2'd0, 64'h7F80_10F0_7F80_0000, 64'h01FF_10F0_7F80_0000, 64'h7F80_20E0_7F80_0000}, // R3
    {4'd4, 2'd1, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0003_8000, 64'h8000_7FFF_0002_7FFF}, // R3
    {4'd2, 2'd0, 64'hFF80_0100_F010_00FE, 64'h0180_0100_2010_0001, 64'hFFFF_0200_FF20_00FF}, // R4
    {4'd5, 2'd1, 64'h0000_0010_FFFF_8000, 64'h0001_0020_0001_7FFF, 64'h0000_0000_FFFE_0001}, // R4
    {4'd1, 2'd2, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_0000_0000}, // R5
    {4'd5, 2'd2, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 64'hFFFF_FFFF_FFFF_FFFF}, // R5
    {4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00}, // R6
    {4'd6, 2'd1, 64'h1234_0000_FFFF_0001, 64'h1234_0001_FFFF_0101, 64'hFFFF_0000_FFFF_0000}, // R6
    {4'd7, 2'd0, 64'h0180_7FFF_0500_FF10, 64'h007F_8000_05FF_FE20, 64'hFF00_FF00_00FF_FF00}, // R7
    {4'd7, 2'd2, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 64'hFFFF_FFFF_0000_0000}, // R7
    {4'd8, 2'd0, 64'hF0F0_F0F0_1234_5678, 64'hFF00_FF00_FFFF_0000, 64'hF000_F000_1234_0000}, // R8
    {4'd9, 2'd1, 64'hF0F0_F0F0_1234_5678, 64'hFF00_FF00_FFFF_0000, 64'h0F00_0F00_EDCB_0000}, // R9
    {4'd10, 2'd0, 64'hF0F0_0000_1234_0000, 64'h0F00_0001_0000_5678, 64'hFFF0_0001_1234_5678}, // R8
    {4'd11, 2'd2, 64'hFFFF_0000_AAAA_5555, 64'h0F0F_0F0F_FFFF_5555, 64'hF0F0_0F0F_5555_0000}, // R8
    {4'd15, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000}, // R12
    {4'd6, 2'd3, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000}  // R1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_op = op; in_size = sz; in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] d1, d2, absd;
    repeat (3) @(negedge clk);
    check("R11 reset valid", {63'd0, out_valid}, 64'd0);
    check("R11 reset result", out_result, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][197:194], VEC[i][193:192], VEC[i][191:128], VEC[i][127:64]);
      check($sformatf("vector %0d (R1..R12 table)", i), out_result, VEC[i][63:0]);
      check("R11 valid follows", {63'd0, out_valid}, 64'd1);
    end

    // R11: idle cycle holds result, drops valid
    in_valid = 1'b0;
    in_a = 64'hDEAD_BEEF_0000_0000;
    @(negedge clk);
    check("R11 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R11 idle result held", out_result, VEC[NV-1][63:0]);

    // R10: absolute difference via two unsigned saturating subtracts
    issue(4'd5, 2'd0, 64'h1050_00FF_807F_3300, 64'h2040_FF00_7F80_3301);
    d1 = out_result;
    issue(4'd5, 2'd0, 64'h2040_FF00_7F80_3301, 64'h1050_00FF_807F_3300);
    d2 = out_result;
    for (int k = 0; k < 8; k++) begin
      int x, y;
      x = int'(64'h1050_00FF_807F_3300 >> (8*k)) & 255;
      y = int'(64'h2040_FF00_7F80_3301 >> (8*k)) & 255;
      absd[8*k +: 8] = 8'((x > y) ? x - y : y - x);
    end
    check("R10 abs diff", d1 | d2, absd);

    // R5 unsigned add wraps at 32-bit lanes
    issue(4'd2, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0002_0000_0001);
    check("R5 usat add 32b wraps", out_result, 64'h0000_0001_0000_0002);

    // R11: reset while valid clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 mid reset valid", {63'd0, out_valid}, 64'd0);
    check("R11 mid reset result", out_result, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule